// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Controller

This block holds the digital sequencing for a 10-bit successive-approximation analog-to-digital converter and sits behind a small memory-mapped register port. Software writes one control/status word to pick an input channel, a mode code and the notification path (CPU interrupt or DMA request), and to set a start bit. The controller then drives the analog multiplexer select and a sample strobe for one cycle. After that it runs ten bit trials from the most significant bit down. In each trial it presents a code to an external DAC and reads back a single comparator bit.

When the last trial ends, the 10-bit code is stored left-aligned in a 16-bit result register for the channel that was converted. In the same cycle a completion flag is raised and the start bit drops. Software clears the completion flag in two steps: it must first read the flag while it is set, and only then write 0 to it. Software can abort a conversion at any time by writing 0 to the start bit. The mode field takes single, multi and scan codes, and every code is run as one single conversion.

Top module: `adc_sar_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irqOut`, `dmaReq`, `sampleEn` and `dacCode` are 0.
- R2: Register address 8 holds the control/status word. Its bit 0 is start/busy, bit 1 is the done flag, bit 2 is interrupt enable, bit 3 is DMA select, bits 5:4 are the mode and bits 10:8 are the channel. While the block is idle, a write with bit 0 = 1 starts a conversion on the channel in that same write (for example, code 001 selects input 1). `muxSel` shows that channel, and bit 0 reads 1 until the conversion ends.
- R3: A conversion takes one sample cycle (`sampleEn` = 1, `dacCode` = 0), followed by ten trial cycles from bit 9 down to bit 0. Each trial presents the kept bits with the trial bit set, and keeps the trial bit when `cmpIn` = 1 (input at or above the DAC level). The result is therefore the largest code not above the input. It is visible 11 clock edges after the start write edge.
- R4: At completion the code is written, shifted left by 6 with the low 6 bits 0, into the result register at address = channel. In the same cycle the done flag becomes 1 and the start bit becomes 0.
- R5: The done flag clears only on a write of 0 to bit 1 that follows a read of address 8 made while the flag was 1. A write of 0 without that read leaves the flag at 1, and writing 1 to the flag has no effect.
- R6: `irqOut` is 1 exactly when the done flag = 1, interrupt enable = 1 and DMA select = 0.
- R7: When a conversion completes with DMA select = 1, `dmaReq` goes to 1 while the done flag and DMA select stay 1. A read of any result register (addresses 0 to 7) drops it.
- R8: A write of 0 to the start bit during a conversion stops it on that edge. `dacCode` returns to 0, and the result registers and the done flag keep their values.
- R9: Mode codes 00 (single), 01 (multi), 10 (scan) and 11 are all stored and read back, and each one runs one conversion with the same timing as single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (has side effects on the edge) |
| regAddr | input | 4 | Register address: 0..7 results, 8 control/status |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| dacCode | output | 10 | Code presented to the external DAC |
| muxSel | output | 3 | Analog input channel select |
| sampleEn | output | 1 | Sample-and-hold strobe |
| cmpIn | input | 1 | Comparator: 1 when input is at or above the DAC level |
| irqOut | output | 1 | Interrupt request |
| dmaReq | output | 1 | DMA transfer request |

## Verification
The hardest state to reach is the two-step clear of the done flag. Along the way, a plain read of the control word arms the clear, so a check that only looks at the flag can hide a missing read-before-write rule. The bench therefore writes 0 to the flag first, before the control word is ever read, checks through `irqOut` that the flag is still set, and only then reads and writes again. An abort in the middle of the trial sequence is placed at a counted clock edge, so the result register of the aborted channel and the done flag can be compared with their values before the conversion started.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

  // control/status word field positions
  localparam int CTL_GO      = 0;
  localparam int CTL_DONE    = 1;
  localparam int CTL_IRQEN   = 2;
  localparam int CTL_DMASEL  = 3;
  localparam int CTL_MODE_LO = 4;
  localparam int CTL_CH_LO   = 8;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_MULTI  = 2'b01,
    MODE_SCAN   = 2'b10,
    MODE_RSVD   = 2'b11
  } adcMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAcc;     // load first trial mask, zero accumulator
    logic trialActive;  // a bit trial is on the DAC this cycle
    logic stepTrial;    // take comparator decision at this edge
    logic commit;       // store final code into result register
  } sarStrobe_t;

endpackage

// File: rtl/adc_sar_fsm.sv
module adc_sar_fsm
  import adc_sar_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int CH_W     = 3,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrCtl,
  input  logic              rdCtl,
  input  logic              rdResult,
  input  logic [DATA_W-1:0] wrData,
  output sarStrobe_t        strb,
  output logic [CH_W-1:0]   convCh,
  output logic [DATA_W-1:0] ctlWord,
  output logic              busy,
  output logic              doneFlag,
  output logic              irqOut,
  output logic              dmaReq,
  output logic              sampleEn
);

  localparam int CNT_W = $clog2(RES_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RES_BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_TRIAL} convState_e;

  convState_e stateQ;
  logic [CNT_W-1:0] trialCnt;
  logic irqEn, dmaSel, clearArmed, dmaPend;
  logic [1:0] modeSel;
  logic [CH_W-1:0] chSel;
  logic startReq, abortReq, clearReq;

  assign busy     = (stateQ != ST_IDLE);
  assign startReq = wrCtl && wrData[CTL_GO] && !busy;
  assign abortReq = wrCtl && !wrData[CTL_GO] && busy;
  assign clearReq = wrCtl && !wrData[CTL_DONE] && clearArmed;

  always_comb begin
    strb.clearAcc    = startReq;
    strb.trialActive = (stateQ == ST_TRIAL);
    strb.stepTrial   = (stateQ == ST_TRIAL) && !abortReq;
    strb.commit      = (stateQ == ST_TRIAL) && (trialCnt == '0) && !abortReq;
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      trialCnt <= '0;
      convCh   <= '0;
    end else if (startReq) begin
      stateQ <= ST_SAMPLE;
      convCh <= wrData[CTL_CH_LO +: CH_W];
    end else if (abortReq) begin
      stateQ <= ST_IDLE;
    end else begin
      case (stateQ)
        ST_SAMPLE: begin
          stateQ   <= ST_TRIAL;
          trialCnt <= LAST_IDX;
        end
        ST_TRIAL: begin
          if (trialCnt == '0) stateQ <= ST_IDLE;
          else trialCnt <= trialCnt - 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // configuration fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      dmaSel  <= 1'b0;
      modeSel <= MODE_SINGLE;
      chSel   <= '0;
    end else if (wrCtl) begin
      irqEn   <= wrData[CTL_IRQEN];
      dmaSel  <= wrData[CTL_DMASEL];
      modeSel <= wrData[CTL_MODE_LO +: 2];
      chSel   <= wrData[CTL_CH_LO +: CH_W];
    end
  end

  // done flag with read-then-write-zero clearing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag   <= 1'b0;
      clearArmed <= 1'b0;
    end else if (strb.commit) begin
      doneFlag <= 1'b1;
    end else if (clearReq) begin
      doneFlag   <= 1'b0;
      clearArmed <= 1'b0;
    end else if (rdCtl && doneFlag) begin
      clearArmed <= 1'b1;
    end
  end

  // DMA request pending, acknowledged by a result read
  always_ff @(posedge clk) begin
    if (!rstN) dmaPend <= 1'b0;
    else if (strb.commit) dmaPend <= dmaSel;
    else if (rdResult || clearReq) dmaPend <= 1'b0;
  end

  assign irqOut   = doneFlag && irqEn && !dmaSel;
  assign dmaReq   = dmaPend && doneFlag && dmaSel;
  assign sampleEn = (stateQ == ST_SAMPLE);

  always_comb begin
    ctlWord = '0;
    ctlWord[CTL_GO]                = busy;
    ctlWord[CTL_DONE]              = doneFlag;
    ctlWord[CTL_IRQEN]             = irqEn;
    ctlWord[CTL_DMASEL]            = dmaSel;
    ctlWord[CTL_MODE_LO +: 2]      = modeSel;
    ctlWord[CTL_CH_LO +: CH_W]     = chSel;
  end

endmodule

// File: rtl/adc_sar_datapath.sv
module adc_sar_datapath
  import adc_sar_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int CH_COUNT = 8,
  parameter int DATA_W   = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  sarStrobe_t                  strb,
  input  logic [$clog2(CH_COUNT)-1:0] convCh,
  input  logic                        cmpIn,
  input  logic [$clog2(CH_COUNT)-1:0] rdIdx,
  output logic [RES_BITS-1:0]         dacCode,
  output logic [DATA_W-1:0]           rdData
);

  localparam int PAD_W = DATA_W - RES_BITS;
  localparam logic [RES_BITS-1:0] FIRST_MASK = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] accCode, trialMask, trialCode, finalCode;
  logic [DATA_W-1:0] resultReg [CH_COUNT];

  assign trialCode = accCode | trialMask;
  assign finalCode = cmpIn ? trialCode : accCode;
  assign dacCode   = strb.trialActive ? trialCode : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accCode   <= '0;
      trialMask <= '0;
    end else if (strb.clearAcc) begin
      accCode   <= '0;
      trialMask <= FIRST_MASK;
    end else if (strb.stepTrial) begin
      accCode   <= finalCode;
      trialMask <= trialMask >> 1;
    end
  end

  for (genvar g = 0; g < CH_COUNT; g++) begin : gResult
    always_ff @(posedge clk) begin
      if (!rstN) resultReg[g] <= '0;
      else if (strb.commit && (convCh == g)) resultReg[g] <= {finalCode, {PAD_W{1'b0}}};
    end
  end

  assign rdData = resultReg[rdIdx];

endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_sar_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int CH_COUNT = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic                        regRdEn,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  output logic [DATA_W-1:0]           regRdData,
  output logic [RES_BITS-1:0]         dacCode,
  output logic [$clog2(CH_COUNT)-1:0] muxSel,
  output logic                        sampleEn,
  input  logic                        cmpIn,
  output logic                        irqOut,
  output logic                        dmaReq
);

  localparam int CH_W = $clog2(CH_COUNT);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(CH_COUNT);

  sarStrobe_t strb;
  logic [CH_W-1:0] convCh;
  logic [DATA_W-1:0] ctlWord, resData;
  logic busy, doneFlag, isCtl, isRes, wrCtl, rdCtl, rdResult;

  assign isCtl    = (regAddr == CTL_ADDR);
  assign isRes    = (regAddr < CTL_ADDR);
  assign wrCtl    = regWrEn && isCtl;
  assign rdCtl    = regRdEn && isCtl;
  assign rdResult = regRdEn && isRes;

  adc_sar_fsm #(.RES_BITS(RES_BITS), .CH_W(CH_W), .DATA_W(DATA_W)) uFsm (
    .clk(clk), .rstN(rstN), .wrCtl(wrCtl), .rdCtl(rdCtl), .rdResult(rdResult),
    .wrData(regWrData), .strb(strb), .convCh(convCh), .ctlWord(ctlWord),
    .busy(busy), .doneFlag(doneFlag), .irqOut(irqOut), .dmaReq(dmaReq),
    .sampleEn(sampleEn)
  );

  adc_sar_datapath #(.RES_BITS(RES_BITS), .CH_COUNT(CH_COUNT), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .convCh(convCh), .cmpIn(cmpIn),
    .rdIdx(regAddr[CH_W-1:0]), .dacCode(dacCode), .rdData(resData)
  );

  assign muxSel    = convCh;
  assign regRdData = isCtl ? ctlWord : (isRes ? resData : '0);

endmodule

// File: rtl/adc_sar_ctrl_chk.sv
module adc_sar_ctrl_chk
  import adc_sar_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int CH_COUNT = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [DATA_W-1:0]   regWrData,
  input logic                irqOut,
  input logic                dmaReq,
  input logic [RES_BITS-1:0] dacCode,
  input logic                doneFlag,
  input logic                busy,
  input sarStrobe_t          strb
);

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(CH_COUNT);

  p_irq_dma_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && dmaReq));

  p_irq_needs_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> doneFlag);

  p_done_after_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> doneFlag && !busy);

  p_done_clear_by_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(regWrEn && regAddr == CTL_ADDR && !regWrData[CTL_DONE]));

  p_dac_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> dacCode == '0);

  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strb.commit) ||
                    $past(regWrEn && regAddr == CTL_ADDR && !regWrData[CTL_GO]));

endmodule

bind adc_sar_ctrl adc_sar_ctrl_chk #(.RES_BITS(RES_BITS), .ADDR_W(ADDR_W),
                                     .DATA_W(DATA_W), .CH_COUNT(CH_COUNT)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .irqOut(irqOut), .dmaReq(dmaReq), .dacCode(dacCode), .doneFlag(doneFlag),
  .busy(busy), .strb(strb)
);

// File: tb/adc_sar_ctrl_test.sv
module adc_sar_ctrl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [15:0] regWrData = '0, regRdData;
  logic [9:0] dacCode;
  logic [2:0] muxSel;
  logic sampleEn, cmpIn, irqOut, dmaReq;
  int analogLvl = 0;
  int nRun = 0, nFail = 0;

  always #4 clk = ~clk;   // 125 MHz

  assign cmpIn = (int'(dacCode) <= analogLvl);

  adc_sar_ctrl uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dacCode(dacCode), .muxSel(muxSel),
    .sampleEn(sampleEn), .cmpIn(cmpIn), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ctlVal(input bit go, input bit done, input bit ie,
                                         input bit dsel, input bit [1:0] mode, input bit [2:0] ch);
    return {5'b0, ch, 2'b0, mode, dsel, ie, done, go};
  endfunction

  // drive one write; returns at the negedge just after the write edge
  task automatic doWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic clearDone(input logic [15:0] cfg);
    logic [15:0] d;
    doRead(4'd8, d);
    doWrite(4'd8, cfg & ~16'h0003);
  endtask

  task automatic testReset();
    logic [15:0] d;
    for (int a = 0; a <= 8; a++) begin
      doRead(4'(a), d);
      check("R1", $sformatf("reg %0d after reset", a), d, 0);
    end
    check("R1", "irqOut", irqOut, 0);
    check("R1", "dmaReq", dmaReq, 0);
    check("R1", "sampleEn", sampleEn, 0);
    check("R1", "dacCode", dacCode, 0);
  endtask

  task automatic testSingle();
    logic [15:0] d;
    analogLvl = 341;
    doWrite(4'd8, ctlVal(1, 0, 1, 0, 2'b00, 3'd1));
    check("R2", "muxSel", muxSel, 1);
    check("R3", "sampleEn in sample cycle", sampleEn, 1);
    check("R3", "dacCode in sample cycle", dacCode, 0);
    @(negedge clk);
    check("R3", "first trial MSB", dacCode, 512);
    @(negedge clk);
    check("R3", "second trial after reject", dacCode, 256);
    repeat (8) @(negedge clk);
    check("R3", "not done one edge early", irqOut, 0);
    @(negedge clk);
    check("R6", "irq at completion", irqOut, 1);
    doRead(4'd1, d);
    check("R4", "result ch1 left aligned", d, 341 << 6);
    check("R4", "low pad bits", d[5:0], 0);
  endtask

  task automatic testDoneClear();
    logic [15:0] d;
    doWrite(4'd8, ctlVal(0, 0, 1, 0, 2'b00, 3'd1));
    check("R5", "write 0 without read keeps done (irq)", irqOut, 1);
    doRead(4'd8, d);
    check("R5", "done still set", d[1], 1);
    check("R4", "start bit cleared", d[0], 0);
    doWrite(4'd8, ctlVal(0, 0, 1, 0, 2'b00, 3'd1));
    doRead(4'd8, d);
    check("R5", "done cleared after read+write", d[1], 0);
    check("R6", "irq dropped", irqOut, 0);
  endtask

  task automatic testBounds();
    logic [15:0] d;
    analogLvl = 1023;
    doWrite(4'd8, ctlVal(1, 0, 0, 0, 2'b00, 3'd7));
    repeat (11) @(negedge clk);
    doRead(4'd7, d);
    check("R3", "full scale", d, 1023 << 6);
    analogLvl = 0;
    doWrite(4'd8, ctlVal(1, 0, 0, 0, 2'b00, 3'd6));
    repeat (11) @(negedge clk);
    doRead(4'd6, d);
    check("R3", "zero input", d, 0);
    analogLvl = 682;
    doWrite(4'd8, ctlVal(1, 0, 0, 0, 2'b00, 3'd0));
    repeat (11) @(negedge clk);
    doRead(4'd0, d);
    check("R3", "mid code 682", d, 682 << 6);
    clearDone(ctlVal(0, 0, 0, 0, 2'b00, 3'd0));
  endtask

  task automatic testAbort();
    logic [15:0] d;
    analogLvl = 500;
    doWrite(4'd8, ctlVal(1, 0, 1, 0, 2'b00, 3'd2));
    repeat (4) @(negedge clk);
    doWrite(4'd8, ctlVal(0, 0, 1, 0, 2'b00, 3'd2));
    check("R8", "dacCode after abort", dacCode, 0);
    repeat (12) @(negedge clk);
    check("R8", "no irq after abort", irqOut, 0);
    doRead(4'd8, d);
    check("R8", "start bit 0 after abort", d[0], 0);
    check("R8", "done unchanged", d[1], 0);
    doRead(4'd2, d);
    check("R8", "result ch2 unchanged", d, 0);
  endtask

  task automatic testDma();
    logic [15:0] d;
    analogLvl = 777;
    doWrite(4'd8, ctlVal(1, 0, 1, 1, 2'b00, 3'd3));
    repeat (11) @(negedge clk);
    check("R7", "dmaReq at completion", dmaReq, 1);
    check("R6", "irq steered away", irqOut, 0);
    doRead(4'd3, d);
    check("R7", "result ch3", d, 777 << 6);
    check("R7", "dmaReq acked by result read", dmaReq, 0);
    clearDone(ctlVal(0, 0, 0, 0, 2'b00, 3'd3));
  endtask

  task automatic testModes();
    logic [15:0] d;
    for (int m = 1; m < 4; m++) begin
      analogLvl = 100 * m + 3;
      doWrite(4'd8, ctlVal(1, 0, 1, 0, 2'(m), 3'(m + 3)));
      check("R2", "channel from same write", muxSel, m + 3);
      repeat (10) @(negedge clk);
      check("R9", "not done before 11 edges", irqOut, 0);
      @(negedge clk);
      check("R9", "done at 11 edges", irqOut, 1);
      doRead(4'(m + 3), d);
      check("R9", $sformatf("result mode %0d", m), d, (100 * m + 3) << 6);
      doRead(4'd8, d);
      check("R9", "mode readback", d[5:4], m);
      doWrite(4'd8, ctlVal(0, 0, 1, 0, 2'(m), 3'(m + 3)));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSingle();
    testDoneClear();
    testBounds();
    testAbort();
    testDma();
    testModes();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule